// File: doc/BRIEF.md
# Flash Burst Access Engine

This block sits between a word-wide register bus and a serial flash. It moves 32-bit words in either direction through a single shared data FIFO. The host reaches a control/status word, a start-address register and a FIFO window through the bus. For a read burst, the host loads the start address and writes the control word with the read bit and a word count. The engine then fetches that many words from flash into the FIFO, and the host drains them through the window. For writes, the host sets the write bit and pushes words into the window. The engine writes each word to flash at consecutive word addresses. Before each chunk, the host checks the free-space field.

The flash side is one request/acknowledge port that carries an address, a write flag and write data, and returns read data with the acknowledge. Only one request is in flight at a time. After a read burst has been drained, the host writes zero to the control word to return the engine to idle.

Top module: `flash_burst_ctrl`

## Requirements
- R1: After reset, the control word reads 0x0000_2000: no mode, not busy, free space 512, count 0, error clear. `fl_req` is low.
- R2: The control word is at offset 0x40, the address register at 0x44 and the FIFO window at 0x800.
  - Control word fields: bit 0 is write mode, bit 1 is read mode, bit 2 is busy, bits 13:4 are free space in words, bits 25:16 are the read count, and bit 31 is a sticky error.
  - The address register ignores the two low bits written and reads them as zero.
  - Read data appears on `bus_rdata` in the cycle after the read strobe.
- R3: Writing the control word with read mode and a count N in 1..511 reads N words from flash, at the start address and then every 4 bytes. The words come out of the window in address order. Busy stays 1 until the last word is in the FIFO.
- R4: A read count of 0 with read mode set means 512 words. The FIFO is full when the burst ends.
- R5: The free-space field always equals 512 minus the number of words held in the FIFO.
- R6: In write mode (bit 0 set, bit 1 clear), each accepted window write is written to flash at the start address plus 4 per word, in push order. Busy stays 1 while any pushed word is not yet written.
- R7: These accesses are ignored and set the sticky error bit:
  - a window write in write mode while the FIFO is full;
  - a window read in read mode while the FIFO is empty.
  Any accepted control write clears the error bit.
- R8: Writes to the control word or the address register while busy is 1 are ignored.
- R9: `fl_req` stays high, with `fl_addr`, `fl_we` and `fl_wdata` unchanged, until `fl_ack` is seen.
- R10: An accepted control write empties the FIFO. Writing zero after a burst that was not fully drained returns the engine to idle with 512 words free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| fl_req | output | 1 | Flash request |
| fl_we | output | 1 | Flash request is a write |
| fl_addr | output | 32 | Flash byte address |
| fl_wdata | output | 32 | Flash write data |
| fl_ack | input | 1 | Flash acknowledge, one cycle |
| fl_rdata | input | 32 | Flash read data, valid with `fl_ack` |

## Verification
The assertions check four properties on every cycle:
- the FIFO is never pushed when full or popped when empty, and its count never exceeds the depth;
- a flash request holds its address, direction and data until acknowledged;
- a flash write is issued only in write mode;
- control fields do not move after a write that arrived while busy, and the error bit stays set until an accepted control write.

Only the bench's scenarios can show the following: the data order and address stepping of read and write bursts, the meaning of a zero count, the free-space values at burst boundaries, and the discard of undrained words when the engine returns to idle.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam logic [11:0] OFF_CTRL = 12'h040;
  localparam logic [11:0] OFF_ADDR = 12'h044;
  localparam logic [11:0] OFF_WIN  = 12'h800;

  localparam int BIT_WR   = 0;
  localparam int BIT_RD   = 1;
  localparam int BIT_BUSY = 2;
  localparam int FREE_LSB = 4;
  localparam int CNT_LSB  = 16;
  localparam int BIT_ERR  = 31;

  typedef enum logic [1:0] {
    E_IDLE  = 2'd0,
    E_FETCH = 2'd1,
    E_REQ   = 2'd2
  } eng_state_t;
endpackage

// File: rtl/fbc_fifo.sv
module fbc_fifo #(
  parameter int DEPTH = 512,
  parameter int W = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  q,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  // Storage without reset so that a block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (pop && !flush) q <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !flush) |-> (count < CW'(DEPTH)));
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    (pop && !flush) |-> (count != '0));
  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/fbc_engine.sv
module fbc_engine
  import fbc_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [31:0]   load_addr,
  input  logic [CW-1:0] load_words,
  input  logic          rd_mode,
  input  logic          wr_mode,
  input  logic          fifo_empty,
  input  logic          fifo_full,
  input  logic [31:0]   fifo_q,
  output logic          eng_push,
  output logic          eng_pop,
  output logic          busy,
  output logic          fl_req,
  output logic          fl_we,
  output logic [31:0]   fl_addr,
  output logic [31:0]   fl_wdata,
  input  logic          fl_ack
);
  eng_state_t    state;
  logic [31:0]   cur_addr;
  logic [CW-1:0] remaining;
  logic          go_rd, go_wr;

  assign go_rd    = (state == E_IDLE) && !load && rd_mode && (remaining != '0) && !fifo_full;
  assign go_wr    = (state == E_IDLE) && !load && !go_rd && wr_mode && !fifo_empty;
  assign eng_pop  = go_wr;
  assign eng_push = (state == E_REQ) && fl_ack && !fl_we;
  assign busy     = (state != E_IDLE) || (remaining != '0) || (wr_mode && !fifo_empty);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= E_IDLE;
      cur_addr  <= '0;
      remaining <= '0;
      fl_req    <= 1'b0;
      fl_we     <= 1'b0;
      fl_addr   <= '0;
      fl_wdata  <= '0;
    end else begin
      if (load) begin
        cur_addr  <= load_addr;
        remaining <= load_words;
      end
      case (state)
        E_IDLE: begin
          if (go_rd) begin
            fl_req  <= 1'b1;
            fl_we   <= 1'b0;
            fl_addr <= cur_addr;
            state   <= E_REQ;
          end else if (go_wr) begin
            state <= E_FETCH;
          end
        end
        E_FETCH: begin
          fl_req   <= 1'b1;
          fl_we    <= 1'b1;
          fl_addr  <= cur_addr;
          fl_wdata <= fifo_q;
          state    <= E_REQ;
        end
        E_REQ: begin
          if (fl_ack) begin
            fl_req   <= 1'b0;
            cur_addr <= cur_addr + 32'd4;
            if (!fl_we) remaining <= remaining - CW'(1);
            state <= E_IDLE;
          end
        end
        default: state <= E_IDLE;
      endcase
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (fl_req && !fl_ack) |=> (fl_req && $stable(fl_addr) && $stable(fl_we) && $stable(fl_wdata)));
  p_write_in_wr_mode_r6: assert property (@(posedge clk) disable iff (rst)
    (fl_req && fl_we) |-> wr_mode);
endmodule

// File: rtl/flash_burst_ctrl.sv
module flash_burst_ctrl
  import fbc_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int BUS_AW = 12,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              fl_req,
  output logic              fl_we,
  output logic [31:0]       fl_addr,
  output logic [31:0]       fl_wdata,
  input  logic              fl_ack,
  input  logic [31:0]       fl_rdata
);
  logic          wr_q, rd_q, err_q, sel_win_q;
  logic [CW-1:0] cnt_q;
  logic [31:0]   addr_q, reg_rdata_q, status;
  logic          busy, wr_eff;
  logic          ctrl_wr, ctrl_acc, addr_acc, win_wr, win_rd;
  logic          host_push, host_pop, bad_access;
  logic          eng_push, eng_pop;
  logic          f_push, f_pop, f_empty, f_full;
  logic [31:0]   f_wdata, f_q;
  logic [CW-1:0] f_count, free_words, cnt_field, load_words;

  assign ctrl_wr  = bus_en && bus_we && (bus_addr == BUS_AW'(OFF_CTRL));
  assign ctrl_acc = ctrl_wr && !busy;
  assign addr_acc = bus_en && bus_we && (bus_addr == BUS_AW'(OFF_ADDR)) && !busy;
  assign win_wr   = bus_en && bus_we && (bus_addr == BUS_AW'(OFF_WIN));
  assign win_rd   = bus_en && !bus_we && (bus_addr == BUS_AW'(OFF_WIN));

  assign wr_eff     = wr_q && !rd_q;
  assign host_push  = win_wr && wr_eff && !f_full;
  assign host_pop   = win_rd && rd_q && !f_empty;
  assign bad_access = (win_wr && wr_eff && f_full) || (win_rd && rd_q && f_empty);

  assign cnt_field  = bus_wdata[CNT_LSB +: CW];
  assign load_words = !bus_wdata[BIT_RD] ? '0 :
                      (cnt_field == '0) ? CW'(DEPTH) : cnt_field;

  assign f_push  = host_push || eng_push;
  assign f_pop   = host_pop || eng_pop;
  assign f_wdata = wr_eff ? bus_wdata : fl_rdata;
  assign free_words = CW'(DEPTH) - f_count;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      if (ctrl_acc) begin
        wr_q  <= bus_wdata[BIT_WR];
        rd_q  <= bus_wdata[BIT_RD];
        cnt_q <= cnt_field;
        err_q <= 1'b0;
      end else if (bad_access) begin
        err_q <= 1'b1;
      end
      if (addr_acc) addr_q <= {bus_wdata[31:2], 2'b00};
    end
  end

  always_comb begin
    status = '0;
    status[BIT_WR]   = wr_q;
    status[BIT_RD]   = rd_q;
    status[BIT_BUSY] = busy;
    status[FREE_LSB +: CW] = free_words;
    status[CNT_LSB +: CW]  = cnt_q;
    status[BIT_ERR]  = err_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_q <= '0;
      sel_win_q   <= 1'b0;
    end else if (bus_en && !bus_we) begin
      sel_win_q <= (bus_addr == BUS_AW'(OFF_WIN));
      if (bus_addr == BUS_AW'(OFF_CTRL))      reg_rdata_q <= status;
      else if (bus_addr == BUS_AW'(OFF_ADDR)) reg_rdata_q <= addr_q;
      else                                    reg_rdata_q <= '0;
    end
  end

  assign bus_rdata = sel_win_q ? f_q : reg_rdata_q;

  fbc_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (ctrl_acc),
    .push  (f_push),
    .wdata (f_wdata),
    .pop   (f_pop),
    .q     (f_q),
    .count (f_count),
    .empty (f_empty),
    .full  (f_full)
  );

  fbc_engine #(.DEPTH(DEPTH)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .load       (ctrl_acc),
    .load_addr  (addr_q),
    .load_words (load_words),
    .rd_mode    (rd_q),
    .wr_mode    (wr_eff),
    .fifo_empty (f_empty),
    .fifo_full  (f_full),
    .fifo_q     (f_q),
    .eng_push   (eng_push),
    .eng_pop    (eng_pop),
    .busy       (busy),
    .fl_req     (fl_req),
    .fl_we      (fl_we),
    .fl_addr    (fl_addr),
    .fl_wdata   (fl_wdata),
    .fl_ack     (fl_ack)
  );

  p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && busy) |=> ($stable(wr_q) && $stable(rd_q) && $stable(cnt_q)));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (err_q && !ctrl_acc) |=> err_q);
endmodule

// File: tb/flash_burst_ctrl_test.sv
module flash_burst_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fl_req, fl_we;
  logic [31:0] fl_addr, fl_wdata;
  logic        fl_ack;
  logic [31:0] fl_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic stall = 1'b0;

  always #5 clk = ~clk;

  flash_burst_ctrl uut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fl_req(fl_req), .fl_we(fl_we),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_ack(fl_ack), .fl_rdata(fl_rdata)
  );

  function automatic logic [31:0] flash_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] exp_status(input bit wr, input bit rd, input bit bsy,
                                             input int free, input int cnt, input bit err);
    logic [31:0] s;
    s = '0;
    s[0] = wr; s[1] = rd; s[2] = bsy;
    s[13:4] = 10'(free);
    s[25:16] = 10'(cnt);
    s[31] = err;
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Flash model with random latency, stall control and a write log.
  logic [31:0] wlog_addr [1024];
  logic [31:0] wlog_data [1024];
  int          wlog_n = 0;
  logic        pending = 1'b0;
  int unsigned wait_cnt = 0;
  logic [31:0] hold_addr, hold_data;
  logic        hold_we;

  always @(posedge clk) begin
    if (rst) begin
      fl_ack   <= 1'b0;
      fl_rdata <= '0;
      pending  <= 1'b0;
    end else begin
      fl_ack <= 1'b0;
      if (fl_req && !fl_ack) begin
        if (!pending) begin
          pending   <= 1'b1;
          wait_cnt  <= $urandom_range(0, 3);
          hold_addr <= fl_addr;
          hold_we   <= fl_we;
          hold_data <= fl_wdata;
        end else if (wait_cnt != 0) begin
          wait_cnt <= wait_cnt - 1;
        end else if (!stall) begin
          // R9: request fields unchanged since the request was first seen
          check(fl_addr == hold_addr && fl_we == hold_we && (!fl_we || fl_wdata == hold_data),
                "R9 request held", fl_addr, hold_addr);
          fl_ack   <= 1'b1;
          pending  <= 1'b0;
          fl_rdata <= flash_word(fl_addr);
          if (fl_we && wlog_n < 1024) begin
            wlog_addr[wlog_n] <= fl_addr;
            wlog_data[wlog_n] <= fl_wdata;
            wlog_n <= wlog_n + 1;
          end
        end
      end
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    bit ok = 0;
    for (int i = 0; i < 20000; i++) begin
      bus_read(12'h040, s);
      if (!s[2]) begin ok = 1; break; end
    end
    check(ok, tag, 32'(ok), 32'd1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d, a0;
    int n, base;
    void'($urandom(32'd20240607));
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    bus_read(12'h040, d);
    check(d == 32'h0000_2000, "R1 reset status", d, 32'h0000_2000);
    check(fl_req == 1'b0, "R1 no flash request", 32'(fl_req), 32'd0);

    // R2 address register masks low bits
    bus_write(12'h044, 32'h0000_1237);
    bus_read(12'h044, d);
    check(d == 32'h0000_1234, "R2 address register", d, 32'h0000_1234);

    // R3/R5 random read bursts
    for (int t = 0; t < 3; t++) begin
      n  = $urandom_range(1, 511);
      a0 = {$urandom_range(0, 32'h00FF_FFFF), 2'b00};
      bus_write(12'h044, a0);
      bus_write(12'h040, 32'(n) << 16 | 32'h2);
      wait_idle("R3 burst completes");
      bus_read(12'h040, d);
      check(d == exp_status(0, 1, 0, 512 - n, n, 0), "R5 free after burst", d, exp_status(0, 1, 0, 512 - n, n, 0));
      for (int k = 0; k < n; k++) begin
        bus_read(12'h800, d);
        check(d == flash_word(a0 + 32'(4 * k)), "R3 burst data", d, flash_word(a0 + 32'(4 * k)));
      end
      bus_read(12'h040, d);
      check(d[13:4] == 10'd512, "R5 free after drain", 32'(d[13:4]), 32'd512);
      bus_write(12'h040, 32'h0);
    end

    // R4 count zero means 512 words
    a0 = 32'h0010_0000;
    bus_write(12'h044, a0);
    bus_write(12'h040, 32'h2);
    wait_idle("R4 burst completes");
    bus_read(12'h040, d);
    check(d == exp_status(0, 1, 0, 0, 0, 0), "R4 fifo full", d, exp_status(0, 1, 0, 0, 0, 0));
    for (int k = 0; k < 512; k++) begin
      bus_read(12'h800, d);
      check(d == flash_word(a0 + 32'(4 * k)), "R4 burst data", d, flash_word(a0 + 32'(4 * k)));
    end
    // R7 pop from empty FIFO
    bus_read(12'h800, d);
    bus_read(12'h040, d);
    check(d == exp_status(0, 1, 0, 512, 0, 1), "R7 empty pop error", d, exp_status(0, 1, 0, 512, 0, 1));
    bus_write(12'h040, 32'h0);
    bus_read(12'h040, d);
    check(d == 32'h0000_2000, "R7 error cleared", d, 32'h0000_2000);

    // R8 writes while busy are ignored
    stall = 1'b1;
    a0 = 32'h0000_4000;
    bus_write(12'h044, a0);
    bus_write(12'h040, 32'h0008_0002);
    bus_write(12'h040, 32'h0003_0001);
    bus_write(12'h044, 32'h0000_8880);
    bus_read(12'h040, d);
    check(d == exp_status(0, 1, 1, 512, 8, 0), "R8 ctrl unchanged", d, exp_status(0, 1, 1, 512, 8, 0));
    bus_read(12'h044, d);
    check(d == a0, "R8 addr unchanged", d, a0);
    stall = 1'b0;
    wait_idle("R8 burst completes");
    for (int k = 0; k < 8; k++) begin
      bus_read(12'h800, d);
      check(d == flash_word(a0 + 32'(4 * k)), "R8 burst data", d, flash_word(a0 + 32'(4 * k)));
    end
    bus_write(12'h040, 32'h0);

    // R10 undrained burst discarded
    bus_write(12'h044, 32'h0000_0100);
    bus_write(12'h040, 32'h0006_0002);
    wait_idle("R10 burst completes");
    bus_write(12'h040, 32'h0);
    bus_read(12'h040, d);
    check(d == 32'h0000_2000, "R10 idle after zero", d, 32'h0000_2000);
    a0 = 32'h0000_0900;
    bus_write(12'h044, a0);
    bus_write(12'h040, 32'h0003_0002);
    wait_idle("R10 second burst");
    bus_read(12'h800, d);
    check(d == flash_word(a0), "R10 fresh data", d, flash_word(a0));
    bus_write(12'h040, 32'h0);

    // R6 write bursts with random data
    for (int t = 0; t < 3; t++) begin
      logic [31:0] pushed [64];
      n    = $urandom_range(1, 40);
      a0   = {$urandom_range(0, 32'h00FF_FFFF), 2'b00};
      base = wlog_n;
      bus_write(12'h044, a0);
      bus_write(12'h040, 32'h1);
      for (int k = 0; k < n; k++) begin
        pushed[k] = $urandom;
        bus_write(12'h800, pushed[k]);
      end
      wait_idle("R6 writes drain");
      check(wlog_n - base == n, "R6 write count", 32'(wlog_n - base), 32'(n));
      for (int k = 0; k < n; k++) begin
        check(wlog_addr[base + k] == a0 + 32'(4 * k), "R6 write addr", wlog_addr[base + k], a0 + 32'(4 * k));
        check(wlog_data[base + k] == pushed[k], "R6 write data", wlog_data[base + k], pushed[k]);
      end
      bus_read(12'h040, d);
      check(d == exp_status(1, 0, 0, 512, 0, 0), "R6 status after", d, exp_status(1, 0, 0, 512, 0, 0));
      bus_write(12'h040, 32'h0);
    end

    // R7 push into full FIFO
    stall = 1'b1;
    a0   = 32'h0200_0000;
    base = wlog_n;
    bus_write(12'h044, a0);
    bus_write(12'h040, 32'h1);
    for (int k = 0; k < 600; k++) bus_write(12'h800, 32'hC000_0000 + 32'(k));
    bus_read(12'h040, d);
    check(d == exp_status(1, 0, 1, 0, 0, 1), "R7 full push error", d, exp_status(1, 0, 1, 0, 0, 1));
    stall = 1'b0;
    wait_idle("R7 full drain");
    n = wlog_n - base;
    check(n >= 512 && n <= 514, "R7 accepted words", 32'(n), 32'd513);
    for (int k = 0; k < n; k++) begin
      check(wlog_data[base + k] == 32'hC000_0000 + 32'(k) && wlog_addr[base + k] == a0 + 32'(4 * k),
            "R7 prefix order", wlog_data[base + k], 32'hC000_0000 + 32'(k));
    end
    bus_write(12'h040, 32'h0);
    bus_read(12'h040, d);
    check(d == 32'h0000_2000, "R7 cleared by ctrl", d, 32'h0000_2000);

    finish_run();
  end
endmodule